// File: doc/BRIEF.md
# Register Rename Load Scoreboard

This block keeps the rename state for the four 8-bit architectural registers of a small CPU core that issues one instruction per cycle, strictly in program order, while memory loads finish later and out of order. When a load issues, its destination register is bound to a fresh tag taken from a small pool, and the load proceeds in the background. Any later instruction that reads that register has two options. It can accept the tag as the operand's name and issue at once. A store does this, because its data can be filled in later. Otherwise it waits until the value arrives. A value arriving on the completion port in the same cycle is forwarded straight to the reader.

Stores are posted and never hold up issue by themselves. An ALU result is handed in at issue and written at once, which supersedes any load still in flight to the same register. When that superseded load completes later, its tag is released without touching the register. A flush request holds off all issue until every outstanding load has drained, after which every register reads as ready.

Top module: `rename_scoreboard`

## Requirements
- R1: After reset every register holds 0 and is ready, no tag is in use, the stall output is low and no writeback is signalled.
- R2: An accepted load takes the lowest-numbered free tag, presented on `iss_ld_tag` in the issue cycle, and its destination reads as pending under that tag from the next cycle.
- R3: An instruction with `iss_accept_tag` set that reads a pending register issues without stalling and receives the pending flag and the register's current tag instead of a value.
- R4: An instruction with `iss_accept_tag` clear stalls while a source it enables is pending, unless the completion port delivers that source's current tag in the same cycle, in which case it issues with the delivered data as the operand value.
- R5: A store (`iss_is_store`) takes no tag and changes no register, even when `iss_dst_en` is set, and never stalls for a pending source when it accepts tags.
- R6: When all tags are in use a load stalls, while a non-load instruction whose sources are ready still issues.
- R7: A completion whose tag is the current tag of its register writes the data into that register, raises `ld_wb_valid` with register index and data in that cycle, and frees the tag; register reads then match a sequential program-order model.
- R8: A completion whose register has since been rewritten frees its tag without writing the register and without raising `ld_wb_valid`.
- R9: A non-load, non-store instruction with `iss_dst_en` set writes `iss_wr_data` to the destination, which reads as ready with that value from the next cycle.
- R10: A `flush_req` pulse stalls every issue, in that cycle and afterwards, until all outstanding loads have completed; after that, all registers are ready.
- R11: When an issue writes a register in the same cycle as the completion of that register's current tag, the issuing instruction wins and no writeback is signalled.
- Register indices are 0 to 3 for A, X, Y and Z; tags are 0 to 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush_req | input | 1 | Pulse to drain all loads and clear renames |
| iss_valid | input | 1 | An instruction is offered for issue |
| iss_is_load | input | 1 | Offered instruction is a load into `iss_dst` |
| iss_is_store | input | 1 | Offered instruction is a posted store |
| iss_accept_tag | input | 1 | Instruction can take a pending tag as operand |
| iss_src0_en | input | 1 | First source is used |
| iss_src0 | input | 2 | First source register index |
| iss_src1_en | input | 1 | Second source is used |
| iss_src1 | input | 2 | Second source register index |
| iss_dst_en | input | 1 | Instruction writes `iss_dst` (ALU write) |
| iss_dst | input | 2 | Destination register index |
| iss_wr_data | input | 8 | ALU result written at issue |
| cmp_valid | input | 1 | A load completes this cycle |
| cmp_tag | input | 2 | Tag of the completing load |
| cmp_data | input | 8 | Data returned by the load |
| iss_stall | output | 1 | Offered instruction is not accepted this cycle |
| iss_ld_tag | output | 2 | Tag granted to a load issued this cycle |
| op0_val | output | 8 | First operand value |
| op0_pend | output | 1 | First operand is pending |
| op0_tag | output | 2 | Tag naming the first pending operand |
| op1_val | output | 8 | Second operand value |
| op1_pend | output | 1 | Second operand is pending |
| op1_tag | output | 2 | Tag naming the second pending operand |
| ld_wb_valid | output | 1 | A completing load writes a register |
| ld_wb_reg | output | 2 | Register written by the load |
| ld_wb_data | output | 8 | Data written by the load |

## Verification
Directed sequences come first. They separate a stall on a pending operand from the same-cycle forwarding case, fill the tag pool to show that a load stalls while an ALU write goes through, and let a superseded load complete to show that it frees its tag without a write. They also place an ALU write and a completion on one register in the same cycle, and hold a flush across two staggered completions. A long random program of loads, stores and two-source ALU operations follows, with load latencies drawn from 1 to 10 cycles and completions withheld at random. Each cycle compares the stall decision, the granted tag, the operand values or tags and the writeback against a program-order model, and the register contents are read back at the end.

// File: rtl/rr_pkg.sv
package rr_pkg;

    // Reason an offered instruction is held back, in priority order.
    typedef enum logic [1:0] {
        HOLD_NONE    = 2'd0,
        HOLD_FLUSH   = 2'd1,
        HOLD_NO_TAG  = 2'd2,
        HOLD_OPERAND = 2'd3
    } hold_cause_e;

endpackage

// File: rtl/rr_tag_alloc.sv
module rr_tag_alloc #(
    parameter int NUM_TAGS = 4,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic [NUM_TAGS-1:0] busy,
    output logic                any_free,
    output logic [TAG_W-1:0]    free_idx
);
    // Lowest free index wins: scan from the top so the lowest overrides.
    always_comb begin
        any_free = 1'b0;
        free_idx = '0;
        for (int t = NUM_TAGS - 1; t >= 0; t--) begin
            if (!busy[t]) begin
                any_free = 1'b1;
                free_idx = TAG_W'(t);
            end
        end
    end
endmodule

// File: rtl/rr_cmp_match.sv
module rr_cmp_match #(
    parameter int NUM_REGS = 4,
    parameter int NUM_TAGS = 4,
    localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic                               cmp_valid,
    input  logic [TAG_W-1:0]                   cmp_tag,
    input  logic [NUM_TAGS-1:0]                busy,
    input  logic [NUM_TAGS-1:0][REG_W-1:0]     owner,
    input  logic [NUM_REGS-1:0]                pend,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]     rtag,
    output logic                               live,
    output logic                               hit,
    output logic [REG_W-1:0]                   hit_reg
);
    // A completion is live if its tag is in use; it hits only if the
    // owning register still names that tag.
    always_comb begin
        live    = cmp_valid && busy[cmp_tag];
        hit_reg = owner[cmp_tag];
        hit     = live && pend[hit_reg] && (rtag[hit_reg] == cmp_tag);
    end
endmodule

// File: rtl/rr_src_read.sv
module rr_src_read #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 4,
    parameter int NUM_TAGS = 4,
    localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input  logic [NUM_REGS-1:0][DATA_W-1:0] reg_val,
    input  logic [NUM_REGS-1:0]             reg_pend,
    input  logic [NUM_REGS-1:0][TAG_W-1:0]  reg_tag,
    input  logic                            src_en,
    input  logic [REG_W-1:0]                src_sel,
    input  logic                            hit,
    input  logic [REG_W-1:0]                hit_reg,
    input  logic [DATA_W-1:0]               cmp_data,
    output logic [DATA_W-1:0]               out_val,
    output logic                            out_pend,
    output logic [TAG_W-1:0]                out_tag
);
    logic forward;

    always_comb begin
        forward  = hit && (hit_reg == src_sel);
        out_tag  = reg_tag[src_sel];
        out_val  = forward ? cmp_data : reg_val[src_sel];
        out_pend = src_en && reg_pend[src_sel] && !forward;
    end
endmodule

// File: rtl/rename_scoreboard.sv
module rename_scoreboard #(
    parameter int DATA_W   = 8,
    parameter int NUM_REGS = 4,
    parameter int NUM_TAGS = 4,
    localparam int REG_W   = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1,
    localparam int NUM_SRC = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_req,
    input  logic              iss_valid,
    input  logic              iss_is_load,
    input  logic              iss_is_store,
    input  logic              iss_accept_tag,
    input  logic              iss_src0_en,
    input  logic [REG_W-1:0]  iss_src0,
    input  logic              iss_src1_en,
    input  logic [REG_W-1:0]  iss_src1,
    input  logic              iss_dst_en,
    input  logic [REG_W-1:0]  iss_dst,
    input  logic [DATA_W-1:0] iss_wr_data,
    input  logic              cmp_valid,
    input  logic [TAG_W-1:0]  cmp_tag,
    input  logic [DATA_W-1:0] cmp_data,
    output logic              iss_stall,
    output logic [TAG_W-1:0]  iss_ld_tag,
    output logic [DATA_W-1:0] op0_val,
    output logic              op0_pend,
    output logic [TAG_W-1:0]  op0_tag,
    output logic [DATA_W-1:0] op1_val,
    output logic              op1_pend,
    output logic [TAG_W-1:0]  op1_tag,
    output logic              ld_wb_valid,
    output logic [REG_W-1:0]  ld_wb_reg,
    output logic [DATA_W-1:0] ld_wb_data
);
    import rr_pkg::*;

    typedef struct packed {
        logic [NUM_REGS-1:0][DATA_W-1:0] val;
        logic [NUM_REGS-1:0]             pend;
        logic [NUM_REGS-1:0][TAG_W-1:0]  rtag;
        logic [NUM_TAGS-1:0]             busy;
        logic [NUM_TAGS-1:0][REG_W-1:0]  owner;
        logic                            drain;
    } sb_state_t;

    sb_state_t state_q, state_d;

    logic              any_free_w;
    logic [TAG_W-1:0]  free_idx_w;
    logic              cmp_live_w;
    logic              cmp_hit_w;
    logic [REG_W-1:0]  cmp_reg_w;
    logic [NUM_TAGS-1:0] tag_busy_w;
    logic              draining_w;

    logic [NUM_SRC-1:0]             src_en_w;
    logic [NUM_SRC-1:0][REG_W-1:0]  src_sel_w;
    logic [NUM_SRC-1:0][DATA_W-1:0] src_val_w;
    logic [NUM_SRC-1:0]             src_pend_w;
    logic [NUM_SRC-1:0][TAG_W-1:0]  src_tag_w;

    hold_cause_e hold_w;
    logic        accept_w;
    logic        load_go_w;
    logic        alu_wr_w;

    assign tag_busy_w = state_q.busy;
    assign draining_w = state_q.drain;

    rr_tag_alloc #(.NUM_TAGS(NUM_TAGS)) u_alloc (
        .busy     (state_q.busy),
        .any_free (any_free_w),
        .free_idx (free_idx_w)
    );

    rr_cmp_match #(.NUM_REGS(NUM_REGS), .NUM_TAGS(NUM_TAGS)) u_match (
        .cmp_valid (cmp_valid),
        .cmp_tag   (cmp_tag),
        .busy      (state_q.busy),
        .owner     (state_q.owner),
        .pend      (state_q.pend),
        .rtag      (state_q.rtag),
        .live      (cmp_live_w),
        .hit       (cmp_hit_w),
        .hit_reg   (cmp_reg_w)
    );

    assign src_en_w  = {iss_src1_en, iss_src0_en};
    assign src_sel_w = {iss_src1, iss_src0};

    generate
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            rr_src_read #(
                .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .NUM_TAGS(NUM_TAGS)
            ) u_read (
                .reg_val  (state_q.val),
                .reg_pend (state_q.pend),
                .reg_tag  (state_q.rtag),
                .src_en   (src_en_w[s]),
                .src_sel  (src_sel_w[s]),
                .hit      (cmp_hit_w),
                .hit_reg  (cmp_reg_w),
                .cmp_data (cmp_data),
                .out_val  (src_val_w[s]),
                .out_pend (src_pend_w[s]),
                .out_tag  (src_tag_w[s])
            );
        end
    endgenerate

    always_comb begin
        state_d = state_q;

        // Hold decision, highest priority first.
        hold_w = HOLD_NONE;
        if (iss_valid) begin
            if (state_q.drain || flush_req)
                hold_w = HOLD_FLUSH;
            else if (iss_is_load && !any_free_w)
                hold_w = HOLD_NO_TAG;
            else if (!iss_accept_tag && (|src_pend_w))
                hold_w = HOLD_OPERAND;
        end
        accept_w  = iss_valid && (hold_w == HOLD_NONE);
        load_go_w = accept_w && iss_is_load;
        alu_wr_w  = accept_w && !iss_is_load && !iss_is_store && iss_dst_en;

        // Load completion: release the tag, write only if still current.
        if (cmp_live_w)
            state_d.busy[cmp_tag] = 1'b0;
        if (cmp_hit_w) begin
            state_d.val[cmp_reg_w]  = cmp_data;
            state_d.pend[cmp_reg_w] = 1'b0;
        end

        // Issue effects come after, so they override a same-cycle completion.
        if (load_go_w) begin
            state_d.busy[free_idx_w]  = 1'b1;
            state_d.owner[free_idx_w] = iss_dst;
            state_d.pend[iss_dst]     = 1'b1;
            state_d.rtag[iss_dst]     = free_idx_w;
        end
        if (alu_wr_w) begin
            state_d.val[iss_dst]  = iss_wr_data;
            state_d.pend[iss_dst] = 1'b0;
        end

        // Flush: hold until the tag pool is empty, then clear every rename.
        state_d.drain = (state_q.drain || flush_req) && (|state_d.busy);
        if ((state_q.drain || flush_req) && !state_d.drain)
            state_d.pend = '0;

        ld_wb_valid = cmp_hit_w && !((load_go_w || alu_wr_w) && (iss_dst == cmp_reg_w));
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            state_q <= '0;
        else
            state_q <= state_d;
    end

    assign iss_stall  = (hold_w != HOLD_NONE);
    assign iss_ld_tag = free_idx_w;
    assign ld_wb_reg  = cmp_reg_w;
    assign ld_wb_data = cmp_data;
    assign op0_val    = src_val_w[0];
    assign op0_pend   = src_pend_w[0];
    assign op0_tag    = src_tag_w[0];
    assign op1_val    = src_val_w[1];
    assign op1_pend   = src_pend_w[1];
    assign op1_tag    = src_tag_w[1];

endmodule

// File: rtl/rename_scoreboard_checker.sv
module rename_scoreboard_checker #(
    parameter int DATA_W   = 8,
    parameter int NUM_TAGS = 4,
    localparam int TAG_W   = (NUM_TAGS > 1) ? $clog2(NUM_TAGS) : 1
) (
    input logic                clk,
    input logic                rst_n,
    input logic                iss_valid,
    input logic                iss_is_load,
    input logic                iss_accept_tag,
    input logic                iss_src0_en,
    input logic                iss_stall,
    input logic [TAG_W-1:0]    iss_ld_tag,
    input logic                op0_pend,
    input logic                cmp_valid,
    input logic [TAG_W-1:0]    cmp_tag,
    input logic [DATA_W-1:0]   cmp_data,
    input logic                ld_wb_valid,
    input logic [DATA_W-1:0]   ld_wb_data,
    input logic [NUM_TAGS-1:0] tag_busy,
    input logic                draining
);
    // R6: a full tag pool holds back every load.
    p_full_pool_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_is_load && (&tag_busy)) |-> iss_stall);

    // R2: a granted tag is never one already in use.
    p_grant_is_free_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && iss_is_load && !iss_stall) |-> !tag_busy[iss_ld_tag]);

    // R7: a writeback only accompanies a live completion and carries its data.
    p_wb_from_cmp_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ld_wb_valid |-> (cmp_valid && tag_busy[cmp_tag] && ld_wb_data == cmp_data));

    // R8: a live completion always leaves its tag free afterwards.
    p_tag_released_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_valid && tag_busy[cmp_tag]) |=> !tag_busy[$past(cmp_tag)]);

    // R10: nothing issues while a flush is draining.
    p_drain_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (draining && iss_valid) |-> iss_stall);

    // R4: an instruction that cannot take tags never issues on a pending operand.
    p_value_operand_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (iss_valid && !iss_stall && !iss_accept_tag && iss_src0_en) |-> !op0_pend);
endmodule

bind rename_scoreboard rename_scoreboard_checker #(
    .DATA_W(DATA_W), .NUM_TAGS(NUM_TAGS)
) u_checker (
    .clk            (clk),
    .rst_n          (rst_n),
    .iss_valid      (iss_valid),
    .iss_is_load    (iss_is_load),
    .iss_accept_tag (iss_accept_tag),
    .iss_src0_en    (iss_src0_en),
    .iss_stall      (iss_stall),
    .iss_ld_tag     (iss_ld_tag),
    .op0_pend       (op0_pend),
    .cmp_valid      (cmp_valid),
    .cmp_tag        (cmp_tag),
    .cmp_data       (cmp_data),
    .ld_wb_valid    (ld_wb_valid),
    .ld_wb_data     (ld_wb_data),
    .tag_busy       (tag_busy_w),
    .draining       (draining_w)
);

// File: tb/rename_scoreboard_test.sv
`timescale 1ns/1ps
module rename_scoreboard_test;
    localparam int NR = 4;
    localparam int NT = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush_req = 0, iss_valid = 0, iss_is_load = 0, iss_is_store = 0;
    logic iss_accept_tag = 0, iss_src0_en = 0, iss_src1_en = 0, iss_dst_en = 0;
    logic [1:0] iss_src0 = 0, iss_src1 = 0, iss_dst = 0, cmp_tag = 0;
    logic [7:0] iss_wr_data = 0, cmp_data = 0;
    logic cmp_valid = 0;
    logic iss_stall, op0_pend, op1_pend, ld_wb_valid;
    logic [1:0] iss_ld_tag, op0_tag, op1_tag, ld_wb_reg;
    logic [7:0] op0_val, op1_val, ld_wb_data;

    always #2.5 clk = ~clk;

    rename_scoreboard uut (
        .clk(clk), .rst_n(rst_n), .flush_req(flush_req), .iss_valid(iss_valid),
        .iss_is_load(iss_is_load), .iss_is_store(iss_is_store),
        .iss_accept_tag(iss_accept_tag), .iss_src0_en(iss_src0_en),
        .iss_src0(iss_src0), .iss_src1_en(iss_src1_en), .iss_src1(iss_src1),
        .iss_dst_en(iss_dst_en), .iss_dst(iss_dst), .iss_wr_data(iss_wr_data),
        .cmp_valid(cmp_valid), .cmp_tag(cmp_tag), .cmp_data(cmp_data),
        .iss_stall(iss_stall), .iss_ld_tag(iss_ld_tag),
        .op0_val(op0_val), .op0_pend(op0_pend), .op0_tag(op0_tag),
        .op1_val(op1_val), .op1_pend(op1_pend), .op1_tag(op1_tag),
        .ld_wb_valid(ld_wb_valid), .ld_wb_reg(ld_wb_reg), .ld_wb_data(ld_wb_data)
    );

    int checks = 0;
    int fails = 0;

    // Program-order model and tag bookkeeping kept by the bench.
    logic [7:0] m_reg [NR];
    bit         b_pend [NR];
    int         b_tag [NR];
    bit         t_busy [NT];
    int         t_reg [NT];
    int         t_cnt [NT];
    logic [7:0] t_data [NT];
    bit         b_drain = 0;
    int         next_lat = 1;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    // kind: 0 = ALU, 1 = load, 2 = store
    task automatic cyc(input bit v, input int kind, input int s0, input bit s0e,
                       input int s1, input bit s1e, input bit de, input int dst,
                       input bit acc, input logic [7:0] wd, input logic [7:0] ld,
                       input bit cv, input int ct, input logic [7:0] cd,
                       input bit fl, output bit took);
        bit exp_st, p0, p1, hit, ovr, live, anyb;
        int ftag, hr;
        string lbl;
        @(negedge clk);
        iss_valid = v; iss_is_load = (kind == 1); iss_is_store = (kind == 2);
        iss_accept_tag = acc; iss_src0_en = s0e; iss_src0 = 2'(s0);
        iss_src1_en = s1e; iss_src1 = 2'(s1); iss_dst_en = de; iss_dst = 2'(dst);
        iss_wr_data = wd; cmp_valid = cv; cmp_tag = 2'(ct); cmp_data = cd;
        flush_req = fl;
        ftag = -1;
        for (int t = NT - 1; t >= 0; t--) if (!t_busy[t]) ftag = t;
        live = cv && t_busy[ct];
        hr   = t_reg[ct];
        hit  = live && b_pend[hr] && (b_tag[hr] == ct);
        p0 = s0e && b_pend[s0] && !(hit && hr == s0);
        p1 = s1e && b_pend[s1] && !(hit && hr == s1);
        exp_st = v && (b_drain || fl || (kind == 1 && ftag < 0) || (!acc && (p0 || p1)));
        took = v && !exp_st;
        ovr = took && (kind == 1 || (kind == 0 && de)) && (dst == hr);
        #1;
        if (v && (b_drain || fl)) lbl = "R10";
        else if (v && kind == 1 && ftag < 0) lbl = "R6";
        else lbl = "R4";
        chk(iss_stall == exp_st, lbl, iss_stall, exp_st);
        if (took && kind == 1) chk(iss_ld_tag == 2'(ftag), "R2", iss_ld_tag, ftag);
        if (took && s0e) begin
            if (p0) chk(op0_pend && op0_tag == 2'(b_tag[s0]), "R3", op0_tag, b_tag[s0]);
            else    chk(!op0_pend && op0_val == m_reg[s0], "R7", op0_val, m_reg[s0]);
        end
        if (took && s1e) begin
            if (p1) chk(op1_pend && op1_tag == 2'(b_tag[s1]), "R3", op1_tag, b_tag[s1]);
            else    chk(!op1_pend && op1_val == m_reg[s1], "R7", op1_val, m_reg[s1]);
        end
        lbl = hit ? (ovr ? "R11" : "R7") : "R8";
        chk(ld_wb_valid == (hit && !ovr), lbl, ld_wb_valid, hit && !ovr);
        if (hit && !ovr)
            chk(ld_wb_reg == 2'(hr) && ld_wb_data == cd, "R7", ld_wb_data, cd);
        @(posedge clk);
        if (live) begin
            if (hit) b_pend[hr] = 0;
            t_busy[ct] = 0;
        end
        if (took && kind == 1) begin
            t_busy[ftag] = 1; t_reg[ftag] = dst; t_cnt[ftag] = next_lat;
            t_data[ftag] = ld; b_pend[dst] = 1; b_tag[dst] = ftag; m_reg[dst] = ld;
        end else if (took && kind == 0 && de) begin
            m_reg[dst] = wd; b_pend[dst] = 0;
        end
        anyb = 0;
        for (int t = 0; t < NT; t++) anyb |= t_busy[t];
        b_drain = (b_drain || fl) && anyb;
    endtask

    // Read one register through the operand port without changing state.
    task automatic rd(input int r, input logic [7:0] exp, input string req);
        @(negedge clk);
        iss_valid = 1; iss_is_load = 0; iss_is_store = 0; iss_accept_tag = 1;
        iss_src0_en = 1; iss_src0 = 2'(r); iss_src1_en = 0; iss_dst_en = 0;
        cmp_valid = 0; flush_req = 0;
        #1;
        chk(!iss_stall && !op0_pend && op0_val == exp, req, op0_val, exp);
        @(posedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R7 watchdog actual=%0h expected=%0h", 1, 0);
        summary();
        $finish;
    end

    initial begin
        bit took;
        for (int r = 0; r < NR; r++) begin m_reg[r] = 0; b_pend[r] = 0; b_tag[r] = 0; end
        for (int t = 0; t < NT; t++) begin t_busy[t] = 0; t_reg[t] = 0; t_cnt[t] = 0; t_data[t] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R1: reset state
        cyc(0,0,0,0,0,0,0,0,0,8'h00,8'h00,0,0,8'h00,0,took);
        chk(!iss_stall && !ld_wb_valid, "R1", iss_stall, 0);
        for (int r = 0; r < NR; r++) rd(r, 8'h00, "R1");

        // R2: loads into A and X take tags 0 and 1
        next_lat = 0;
        cyc(1,1,0,0,0,0,1,0,0,8'h00,8'h11,0,0,8'h00,0,took);
        cyc(1,1,0,0,0,0,1,1,0,8'h00,8'h22,0,0,8'h00,0,took);
        // R3 / R5: store reading pending A, with a stray destination write request
        cyc(1,2,0,1,0,0,1,0,1,8'hEE,8'h00,0,0,8'h00,0,took);
        chk(took, "R5", took, 1);
        // R4: dependent ALU stalls, then issues with the forwarded value
        cyc(1,0,0,1,0,0,1,2,0,8'h12,8'h00,0,0,8'h00,0,took);
        chk(!took, "R4", took, 0);
        cyc(1,0,0,1,0,0,1,2,0,8'h12,8'h00,1,0,8'h11,0,took);
        chk(took, "R4", took, 1);
        rd(0, 8'h11, "R5");
        rd(2, 8'h12, "R9");

        // R6: fill the pool, then a load stalls while an ALU write issues
        cyc(1,1,0,0,0,0,1,2,0,8'h00,8'h33,0,0,8'h00,0,took);
        cyc(1,1,0,0,0,0,1,3,0,8'h00,8'h44,0,0,8'h00,0,took);
        cyc(1,1,0,0,0,0,1,0,0,8'h00,8'h55,0,0,8'h00,0,took);
        cyc(1,1,0,0,0,0,1,2,0,8'h00,8'h66,0,0,8'h00,0,took);
        chk(!took, "R6", took, 0);
        cyc(1,0,0,0,0,0,1,1,0,8'h5A,8'h00,0,0,8'h00,0,took);
        chk(took, "R6", took, 1);
        // R8: the superseded load on X (tag 1) completes without writing
        cyc(0,0,0,0,0,0,0,0,0,8'h00,8'h00,1,1,8'h22,0,took);
        rd(1, 8'h5A, "R8");
        // R11: ALU write to Y in the same cycle as Y's load (tag 0) completes
        cyc(1,0,0,0,0,0,1,2,0,8'h77,8'h00,1,0,8'h33,0,took);
        rd(2, 8'h77, "R11");

        // R10: flush with tags 2 (Z) and 3 (A) outstanding
        cyc(1,0,0,0,0,0,1,1,0,8'h01,8'h00,0,0,8'h00,1,took);
        chk(!took, "R10", took, 0);
        cyc(1,0,0,0,0,0,1,1,0,8'h01,8'h00,0,0,8'h00,0,took);
        cyc(1,0,0,0,0,0,1,1,0,8'h01,8'h00,1,2,8'h44,0,took);
        chk(!took, "R10", took, 0);
        cyc(1,0,0,0,0,0,1,1,0,8'h01,8'h00,1,3,8'h55,0,took);
        chk(!took, "R10", took, 0);
        cyc(1,0,0,0,0,0,1,1,0,8'h01,8'h00,0,0,8'h00,0,took);
        chk(took, "R10", took, 1);
        rd(0, 8'h55, "R10");
        rd(3, 8'h44, "R10");
        rd(1, 8'h01, "R10");

        // Random program against the sequential model, random latencies
        for (int n = 0; n < 4000; n++) begin
            int kind, s0, s1, dst, ct, lat;
            bit s0e, s1e, de, cv, acc;
            logic [7:0] ld, wd, k;
            kind = ($urandom % 3);
            s0 = $urandom % NR; s1 = $urandom % NR; dst = $urandom % NR;
            s0e = $urandom % 2; s1e = $urandom % 2; de = (kind != 0) ? ($urandom % 2) : 1'b1;
            if (kind == 1) begin s1e = 0; de = 1; end
            acc = (kind == 2);
            ld = 8'($urandom); k = 8'($urandom);
            lat = 1 + ($urandom % 10);
            took = 0;
            while (!took) begin
                ct = -1;
                for (int t = NT - 1; t >= 0; t--) if (t_busy[t] && t_cnt[t] == 0) ct = t;
                cv = (ct >= 0) && ($urandom % 4 != 0);
                if (ct < 0) ct = 0;
                wd = k + (s0e ? m_reg[s0] : 8'h00) + (s1e ? m_reg[s1] : 8'h00);
                next_lat = lat;
                cyc(1,kind,s0,s0e,s1,s1e,de,dst,acc,wd,ld,cv,ct,t_data[ct],0,took);
                for (int t = 0; t < NT; t++) if (t_busy[t] && t_cnt[t] > 0) t_cnt[t]--;
            end
        end
        // Drain what remains, then compare every register with the model
        for (int t = 0; t < NT; t++) begin
            if (t_busy[t]) cyc(0,0,0,0,0,0,0,0,0,8'h00,8'h00,1,t,t_data[t],0,took);
        end
        for (int r = 0; r < NR; r++) rd(r, m_reg[r], "R7");

        summary();
        $finish;
    end
endmodule